// File: doc/BRIEF.md
# 64-bit Integer ALU with Pointer Forms

This block is a 64-bit integer execution unit with one register stage at its output. Each cycle it takes an opcode and two register operands. It can also take an immediate, a 2-bit shift count and the index of the register that supplied the second operand. In the next cycle it returns a 64-bit result and an illegal-operand flag.

A single carry-propagate adder handles several kinds of addition. It covers plain and carry-in add and subtract, adds and subtracts with a short immediate, and an add with a long immediate. It also covers shift-then-add, and a family of 32-bit pointer adds. A pointer add keeps only the low half of the sum and moves two region bits of the second operand into the upper half. A separate bitwise unit covers the logical operations. An extension unit widens 8-, 16- and 32-bit values with a sign fill or a zero fill.

The long-immediate add is legal only when the second operand comes from one of the lowest four registers. For any other register it raises the illegal flag and returns a zero result.

Top module: `xalu64`

## Requirements
- R1: While `rst_n` is low, `result` and `illegal` are zero.
- R2: Outputs change only at a rising clock edge and show the inputs sampled at that edge, which gives one cycle of latency.
- R3: The two- and three-input arithmetic forms use these opcodes: 0 gives a+b, 1 gives a+b+1, 2 gives a-b, 3 gives a-b-1. All results are modulo 2^64.
- R4: Opcode 4 gives S+b and opcode 5 gives S-b. S is `imm[14:0]` sign-extended from bit 14.
- R5: Opcode 6 gives L+b when `src_idx` is 3 or lower. L is `imm[21:0]` sign-extended from bit 21.
- R6: Opcode 6 with `src_idx` above 3 sets `illegal` and forces `result` to zero. Every other opcode and index leaves `illegal` at 0.
- R7: Opcode 7 gives (a << (sh_cnt+1)) + b, so the shift is 1 to 4 bits.
- R8: The pointer forms are opcode 8 (a+b), opcode 9 (S+b) and opcode 10 ((a << (sh_cnt+1)) + b). Each returns the low 32 bits of its sum in bits 31:0 and b[31:30] in bits 62:61. Bit 63 and bits 60:32 are zero.
- R9: The logical opcodes are 11 a&b, 12 a|b, 13 a^b and 14 a&~b.
- R10: The extension opcodes act on a. Opcodes 15, 16 and 17 sign-extend from 8, 16 and 32 bits. Opcodes 18, 19 and 20 zero-extend from 8, 16 and 32 bits.
- R11: Opcodes 21 to 31 give a zero result with `illegal` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 5 | Operation code |
| opa | input | 64 | First register operand (a) |
| opb | input | 64 | Second register operand (b) |
| imm | input | 22 | Immediate field; short forms use bits 14:0 |
| src_idx | input | 7 | Register index that supplied b |
| sh_cnt | input | 2 | Pre-shift count minus one |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-operand flag |

## Verification
The illegal-index check and the long-immediate add can fall in the same cycle. On an illegal index the flag must rise and the adder output must be suppressed in the same registered update.

This is provoked by sweeping `src_idx` across all 128 values with fixed nonzero operands and immediate, so that the index crosses the 3-to-4 boundary. Each cycle is judged on both outputs together: the sum with the flag clear, or zero with the flag set.

Changing opcode back to back also makes sure a stale flag never follows into a legal operation.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

   localparam int OPC_W     = 5;
   localparam int EXT_SIZES = 3;
   localparam int EXT_BASE  = 8;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD     = 5'd0,
      OP_ADD1    = 5'd1,
      OP_SUB     = 5'd2,
      OP_SUB1    = 5'd3,
      OP_ADDI_S  = 5'd4,
      OP_SUBI_S  = 5'd5,
      OP_ADDI_L  = 5'd6,
      OP_SHLADD  = 5'd7,
      OP_PADD    = 5'd8,
      OP_PADDI   = 5'd9,
      OP_PSHLADD = 5'd10,
      OP_AND     = 5'd11,
      OP_OR      = 5'd12,
      OP_XOR     = 5'd13,
      OP_ANDCM   = 5'd14,
      OP_SX8     = 5'd15,
      OP_SX16    = 5'd16,
      OP_SX32    = 5'd17,
      OP_ZX8     = 5'd18,
      OP_ZX16    = 5'd19,
      OP_ZX32    = 5'd20
   } xalu_op_e;

   typedef enum logic [1:0] {
      GRP_ARITH,
      GRP_LOGIC,
      GRP_EXT,
      GRP_NONE
   } xalu_grp_e;

   typedef struct packed {
      logic use_imm_s;
      logic use_imm_l;
      logic use_shift;
      logic invert_b;
      logic carry_in;
      logic pointer;
   } arith_ctl_t;

endpackage

// File: rtl/xalu_addsub.sv
module xalu_addsub
   import xalu_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int IMM_S_W   = 15,
   parameter int IMM_L_W   = 22,
   parameter int SHIFT_MAX = 4,
   localparam int SH_W     = $clog2(SHIFT_MAX),
   localparam int HALF_W   = DATA_W / 2
) (
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   input  logic [IMM_L_W-1:0] imm,
   input  logic [SH_W-1:0]    sh_cnt,
   input  arith_ctl_t         ctl,
   output logic [DATA_W-1:0]  sum
);

   logic [DATA_W-1:0] imm_s_ext;
   logic [DATA_W-1:0] imm_l_ext;
   logic [DATA_W-1:0] shifted [SHIFT_MAX];
   logic [DATA_W-1:0] x_opnd;
   logic [DATA_W-1:0] y_opnd;
   logic [DATA_W-1:0] raw_sum;
   logic [DATA_W-1:0] ptr_sum;

   assign imm_s_ext = {{(DATA_W-IMM_S_W){imm[IMM_S_W-1]}}, imm[IMM_S_W-1:0]};
   assign imm_l_ext = {{(DATA_W-IMM_L_W){imm[IMM_L_W-1]}}, imm[IMM_L_W-1:0]};

   // one pre-shifted copy of a per legal shift amount (1 .. SHIFT_MAX)
   for (genvar g = 0; g < SHIFT_MAX; g++) begin : g_shift
      assign shifted[g] = a << (g + 1);
   end

   always_comb begin
      if (ctl.use_imm_l)      x_opnd = imm_l_ext;
      else if (ctl.use_imm_s) x_opnd = imm_s_ext;
      else if (ctl.use_shift) x_opnd = shifted[sh_cnt];
      else                    x_opnd = a;
   end

   assign y_opnd  = ctl.invert_b ? ~b : b;
   assign raw_sum = x_opnd + y_opnd + {{(DATA_W-1){1'b0}}, ctl.carry_in};

   // pointer form: low half of the sum, region bits from b's low half top
   assign ptr_sum = {1'b0, b[HALF_W-1 -: 2], {(HALF_W-3){1'b0}}, raw_sum[HALF_W-1:0]};

   assign sum = ctl.pointer ? ptr_sum : raw_sum;

endmodule

// File: rtl/xalu_logic.sv
module xalu_logic #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        fsel,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (fsel)
         2'd0:    y = a & b;
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = a & ~b;
      endcase
   end

endmodule

// File: rtl/xalu_extend.sv
module xalu_extend #(
   parameter int DATA_W  = 64,
   parameter int BASE_W  = 8,
   parameter int N_SIZES = 3,
   localparam int SEL_W  = (N_SIZES > 1) ? $clog2(N_SIZES) : 1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [SEL_W-1:0]  size_sel,
   input  logic              sign_en,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] sx [N_SIZES];
   logic [DATA_W-1:0] zx [N_SIZES];

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      localparam int W = BASE_W << g;
      assign sx[g] = {{(DATA_W-W){a[W-1]}}, a[W-1:0]};
      assign zx[g] = {{(DATA_W-W){1'b0}},   a[W-1:0]};
   end

   always_comb begin
      y = '0;
      for (int i = 0; i < N_SIZES; i++) begin
         if (size_sel == SEL_W'(i)) y = sign_en ? sx[i] : zx[i];
      end
   end

endmodule

// File: rtl/xalu64.sv
module xalu64
   import xalu_pkg::*;
#(
   parameter int DATA_W          = 64,
   parameter int IMM_S_W         = 15,
   parameter int IMM_L_W         = 22,
   parameter int SRC_W           = 7,
   parameter int LOW_SRC_LIMIT   = 3,
   parameter int SHIFT_MAX       = 4,
   localparam int SH_W           = $clog2(SHIFT_MAX),
   localparam int HALF_W         = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OPC_W-1:0]   op,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   input  logic [IMM_L_W-1:0] imm,
   input  logic [SRC_W-1:0]   src_idx,
   input  logic [SH_W-1:0]    sh_cnt,
   output logic [DATA_W-1:0]  result,
   output logic               illegal
);

   localparam logic [SRC_W-1:0] LOW_LIM = SRC_W'(LOW_SRC_LIMIT);

   // elaboration-time parameter checks
   if (DATA_W % 2 != 0 || HALF_W < 4) begin : g_chk_width
      $error("xalu64: DATA_W must be even and at least 8");
   end
   if (IMM_S_W >= IMM_L_W || IMM_L_W > DATA_W) begin : g_chk_imm
      $error("xalu64: need IMM_S_W < IMM_L_W <= DATA_W");
   end
   if (SHIFT_MAX != (1 << SH_W) || SHIFT_MAX < 2) begin : g_chk_shift
      $error("xalu64: SHIFT_MAX must be a power of two, at least 2");
   end
   if ((EXT_BASE << (EXT_SIZES - 1)) >= DATA_W) begin : g_chk_ext
      $error("xalu64: widest extension source must be narrower than DATA_W");
   end
   if (LOW_SRC_LIMIT < 0 || LOW_SRC_LIMIT >= (1 << SRC_W)) begin : g_chk_src
      $error("xalu64: LOW_SRC_LIMIT out of range for SRC_W");
   end

   xalu_op_e          op_e;
   xalu_grp_e         grp;
   arith_ctl_t        actl;
   logic [1:0]        lsel;
   logic [OPC_W-1:0]  ext_off;
   logic              ext_sign;
   logic [1:0]        ext_size;
   logic              bad_src;

   logic [DATA_W-1:0] arith_y;
   logic [DATA_W-1:0] logic_y;
   logic [DATA_W-1:0] ext_y;
   logic [DATA_W-1:0] res_d;
   logic [DATA_W-1:0] res_q;
   logic              ill_q;

   assign op_e = xalu_op_e'(op);

   // ---------------- decode ----------------
   always_comb begin
      if (op <= OPC_W'(OP_PSHLADD))     grp = GRP_ARITH;
      else if (op <= OPC_W'(OP_ANDCM))  grp = GRP_LOGIC;
      else if (op <= OPC_W'(OP_ZX32))   grp = GRP_EXT;
      else                              grp = GRP_NONE;
   end

   always_comb begin
      actl = '0;
      case (op_e)
         OP_ADD1:    actl.carry_in  = 1'b1;
         OP_SUB:     begin actl.invert_b = 1'b1; actl.carry_in = 1'b1; end
         OP_SUB1:    actl.invert_b  = 1'b1;
         OP_ADDI_S:  actl.use_imm_s = 1'b1;
         OP_SUBI_S:  begin actl.use_imm_s = 1'b1; actl.invert_b = 1'b1; actl.carry_in = 1'b1; end
         OP_ADDI_L:  actl.use_imm_l = 1'b1;
         OP_SHLADD:  actl.use_shift = 1'b1;
         OP_PADD:    actl.pointer   = 1'b1;
         OP_PADDI:   begin actl.use_imm_s = 1'b1; actl.pointer = 1'b1; end
         OP_PSHLADD: begin actl.use_shift = 1'b1; actl.pointer = 1'b1; end
         default:    actl = '0;
      endcase
   end

   assign lsel     = 2'(op - OPC_W'(OP_AND));
   assign ext_off  = op - OPC_W'(OP_SX8);
   assign ext_sign = ext_off < OPC_W'(EXT_SIZES);
   assign ext_size = ext_sign ? ext_off[1:0] : 2'(ext_off - OPC_W'(EXT_SIZES));
   assign bad_src  = (op_e == OP_ADDI_L) && (src_idx > LOW_LIM);

   // ---------------- datapath ----------------
   xalu_addsub #(
      .DATA_W    (DATA_W),
      .IMM_S_W   (IMM_S_W),
      .IMM_L_W   (IMM_L_W),
      .SHIFT_MAX (SHIFT_MAX)
   ) i_addsub (
      .a      (opa),
      .b      (opb),
      .imm    (imm),
      .sh_cnt (sh_cnt),
      .ctl    (actl),
      .sum    (arith_y)
   );

   xalu_logic #(
      .DATA_W (DATA_W)
   ) i_logic (
      .a    (opa),
      .b    (opb),
      .fsel (lsel),
      .y    (logic_y)
   );

   xalu_extend #(
      .DATA_W  (DATA_W),
      .BASE_W  (EXT_BASE),
      .N_SIZES (EXT_SIZES)
   ) i_extend (
      .a        (opa),
      .size_sel (ext_size),
      .sign_en  (ext_sign),
      .y        (ext_y)
   );

   always_comb begin
      unique case (grp)
         GRP_ARITH: res_d = bad_src ? '0 : arith_y;
         GRP_LOGIC: res_d = logic_y;
         GRP_EXT:   res_d = ext_y;
         default:   res_d = '0;
      endcase
   end

   // ---------------- output stage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         ill_q <= 1'b0;
      end else begin
         res_q <= res_d;
         ill_q <= bad_src;
      end
   end

   assign result  = res_q;
   assign illegal = ill_q;

   // ---------------- assertions ----------------
   // R6
   illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (ill_q == ($past(op) == OPC_W'(OP_ADDI_L) && $past(src_idx) > LOW_LIM)));

   // R6
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ill_q |-> (res_q == '0));

   // R8
   ptr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(op) == OPC_W'(OP_PADD) || $past(op) == OPC_W'(OP_PADDI) ||
                        $past(op) == OPC_W'(OP_PSHLADD)))
      |-> (!res_q[DATA_W-1] && res_q[DATA_W-4:HALF_W] == '0 &&
           res_q[DATA_W-2 -: 2] == $past(opb[HALF_W-1 -: 2])));

   // R3
   add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op) == OPC_W'(OP_ADD1))
      |-> (res_q == $past(opa) + $past(opb) + DATA_W'(1)));

   // R10
   sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op) == OPC_W'(OP_SX8))
      |-> (res_q[DATA_W-1:7] == '0 || (&res_q[DATA_W-1:7])));

   // R10
   zext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op) == OPC_W'(OP_ZX16))
      |-> (res_q[DATA_W-1:16] == '0));

endmodule

// File: tb/test_xalu64.sv
`timescale 1ns/1ps
module test_xalu64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [4:0]  op = '0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic [21:0] imm = '0;
   logic [6:0]  src_idx = '0;
   logic [1:0]  sh_cnt = '0;
   logic [63:0] result;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] prev_res = '0;
   logic        prev_ill = 1'b0;

   always #2 clk = ~clk;

   xalu64 i_xalu64 (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .opa     (opa),
      .opb     (opb),
      .imm     (imm),
      .src_idx (src_idx),
      .sh_cnt  (sh_cnt),
      .result  (result),
      .illegal (illegal)
   );

   function automatic logic [63:0] pat(int i);
      logic [63:0] v;
      case (i % 10)
         0: v = 64'h0;
         1: v = 64'h1;
         2: v = '1;
         3: v = 64'h8000_0000_0000_0000;
         4: v = 64'h7fff_ffff_ffff_ffff;
         5: v = 64'h0000_0000_c000_0000;
         6: v = 64'h0000_0000_4000_8080;
         default: v = 64'(i + 1) * 64'h9e37_79b9_7f4a_7c15;
      endcase
      return v;
   endfunction

   function automatic logic [63:0] ptr(logic [63:0] s, logic [63:0] b);
      return {1'b0, b[31:30], 29'd0, s[31:0]};
   endfunction

   function automatic logic [63:0] model(logic [4:0] o, logic [63:0] a, logic [63:0] b,
                                         logic [21:0] im, logic [6:0] idx, logic [1:0] sh);
      logic [63:0] s15, s22, shl;
      s15 = 64'($signed(im[14:0]));
      s22 = 64'($signed(im));
      shl = a << (32'(sh) + 1);
      case (o)
         5'd0:  return a + b;
         5'd1:  return a + b + 64'd1;
         5'd2:  return a - b;
         5'd3:  return a - b - 64'd1;
         5'd4:  return s15 + b;
         5'd5:  return s15 - b;
         5'd6:  return (idx <= 7'd3) ? s22 + b : 64'd0;
         5'd7:  return shl + b;
         5'd8:  return ptr(a + b, b);
         5'd9:  return ptr(s15 + b, b);
         5'd10: return ptr(shl + b, b);
         5'd11: return a & b;
         5'd12: return a | b;
         5'd13: return a ^ b;
         5'd14: return a & ~b;
         5'd15: return 64'($signed(a[7:0]));
         5'd16: return 64'($signed(a[15:0]));
         5'd17: return 64'($signed(a[31:0]));
         5'd18: return {56'd0, a[7:0]};
         5'd19: return {48'd0, a[15:0]};
         5'd20: return {32'd0, a[31:0]};
         default: return 64'd0;
      endcase
   endfunction

   function automatic string req_of(logic [4:0] o);
      if (o <= 5'd3)  return "R3";
      if (o <= 5'd5)  return "R4";
      if (o == 5'd6)  return "R5/R6";
      if (o == 5'd7)  return "R7";
      if (o <= 5'd10) return "R8";
      if (o <= 5'd14) return "R9";
      if (o <= 5'd20) return "R10";
      return "R11";
   endfunction

   task automatic check(string req, logic [63:0] got, logic [63:0] exp,
                        logic got_ill, logic exp_ill);
      checks++;
      if (got !== exp || got_ill !== exp_ill) begin
         errors++;
         $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                  req, got, got_ill, exp, exp_ill);
      end
   endtask

   // drive at a falling edge, confirm old value holds until the rising edge (R2),
   // then compare at the following falling edge
   task automatic apply(logic [4:0] o, logic [63:0] a, logic [63:0] b,
                        logic [21:0] im, logic [6:0] idx, logic [1:0] sh);
      logic [63:0] e;
      logic        ei;
      @(negedge clk);
      op = o; opa = a; opb = b; imm = im; src_idx = idx; sh_cnt = sh;
      e  = model(o, a, b, im, idx, sh);
      ei = (o == 5'd6) && (idx > 7'd3);
      #1;
      check("R2", result, prev_res, illegal, prev_ill);
      @(negedge clk);
      check(req_of(o), result, e, illegal, ei);
      prev_res = e;
      prev_ill = ei;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      op = 5'd1; opa = '1; opb = 64'h5; imm = '1; src_idx = 7'd9;
      repeat (3) @(negedge clk);
      // R1: held in reset with busy inputs
      check("R1", result, 64'd0, illegal, 1'b0);
      rst_n = 1'b1;
      op = '0; opa = '0; opb = '0; imm = '0; src_idx = '0;

      // sweep all opcodes over operand pairs
      for (int o = 0; o < 32; o++) begin
         for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
               apply(5'(o), pat(ia), pat(ib + 3) ^ 64'(ia),
                     22'(pat(ia * 8 + ib + 2)), 7'((ia * 8 + ib) % 8), 2'((ia + ib) % 4));
            end
         end
      end

      // R5/R6: long-immediate add across every source index
      for (int idx = 0; idx < 128; idx++) begin
         apply(5'd6, 64'hdead_beef, 64'h0123_4567_89ab_cdef, 22'h2a_5a5a, 7'(idx), 2'd0);
         apply(5'd0, 64'h10, 64'h20, 22'h3f_ffff, 7'(idx), 2'd3);
      end

      // R4: short immediate sign boundaries
      apply(5'd4, 64'd0, 64'd100, 22'h00_4000, 7'd0, 2'd0);
      apply(5'd4, 64'd0, 64'd100, 22'h3f_3fff, 7'd0, 2'd0);
      apply(5'd5, 64'd0, 64'd1,   22'h00_4000, 7'd0, 2'd0);

      // R7/R8: every shift count with carries crossing bit 31
      for (int s = 0; s < 4; s++) begin
         apply(5'd7,  64'h8000_0000_ffff_ffff, 64'h1, 22'd0, 7'd0, 2'(s));
         apply(5'd10, 64'hffff_ffff_7fff_ffff, 64'hffff_ffff_bfff_ffff, 22'd0, 7'd0, 2'(s));
      end

      // R1: asynchronous reset in mid run
      apply(5'd2, 64'd5, 64'd9, 22'd0, 7'd0, 2'd0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", result, 64'd0, illegal, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      prev_res = model(op, opa, opb, imm, src_idx, sh_cnt);
      prev_ill = 1'b0;
      @(negedge clk);
      check("R2", result, prev_res, illegal, prev_ill);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got hang expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule